// File: doc/BRIEF.md
# Sigma-Delta Fractional-N Feedback Divider

This block is the feedback divider of a frequency-multiplying PLL. It divides a fast clock, which stands in for the oscillator output, by an average ratio of `div_int + div_frac/div_mod`. Each feedback cycle it picks a whole integer length, either `div_int` or `div_int + 1`. A first-order sigma-delta accumulator makes that choice, so the long-run average carries the fraction. At the end of every feedback cycle the block emits a pulse one fast clock wide. That pulse is the divided clock handed to the phase detector.

Each cycle's integer `Ninst` is split as `Ninst = 4*N1 + N0`, with `N1 = floor(Ninst/4)` and `N0 = Ninst mod 4`. The modulus is built from a 4/5 dual-modulus prescaler and a period counter. The prescaler divides by 5 for the first `N0` of its `N1` periods and by 4 for the rest. A state machine drives the prescaler modulus and has three states:
- `FB_LOAD`: one clock after reset, in which the first cycle is set up.
- `FB_FIVE`: the prescaler periods that divide by 5.
- `FB_FOUR`: the prescaler periods that divide by 4.

Its transitions are:
- start (`FB_LOAD` to `FB_FIVE`, or to `FB_FOUR` when `N0 = 0`).
- swap (`FB_FIVE` to `FB_FOUR` after the last divide-by-5 period).
- step (a period ends but the cycle does not, so the machine stays in its state).
- wrap (the last period of a cycle ends; it reloads and enters `FB_FIVE` or `FB_FOUR` for the next cycle).

The settings are sampled only at a cycle boundary. The operating range is `12 <= div_int <= 2^NW - 2`, `div_mod != 0` and `div_frac < div_mod`.

Top module: `fracn_fb_divider`

## Requirements
- R1: While `rst_n` is low, `fb_pulse` and `cyc_int` are 0. The first feedback cycle after reset release uses `div_int` and lasts `div_int` fast clocks, counted from the first rising edge after release. That first edge is the load clock.
- R2: Every feedback cycle lasts exactly `cyc_int` fast clocks, measured from one pulse to the next.
- R3: `fb_pulse` is high for exactly one fast clock per cycle, on that cycle's final clock.
- R4: At each cycle boundary the block forms `sum = acc + div_frac`. If `sum >= div_mod`, the next cycle uses `div_int + 1` and `acc` becomes `sum - div_mod`. Otherwise the next cycle uses `div_int` and `acc` becomes `sum`. `acc` is 0 after reset. With `div_int=12`, `div_frac=1`, `div_mod=3` the lengths run 12, 12, 13 and then repeat.
- R5: With `div_frac = 0` every cycle uses `div_int`.
- R6: With constant settings, any `div_mod` consecutive cycles starting from reset total `div_mod*div_int + div_frac` fast clocks.
- R7: A change to `div_int`, `div_frac` or `div_mod` in the middle of a cycle leaves that cycle's length unchanged. The new value applies from the next boundary.
- R8: `cyc_int` holds the integer of the cycle in progress and changes only at a cycle boundary.
- R9: Every `Ninst` from 12 to `2^NW - 1` is realised exactly, with all four residues `N0` = 0..3. This includes `N1 = N0` (`Ninst = 15`) and the top value 255 at default width.
- R10: A reset in the middle of a run clears the accumulator, so the first cycle afterwards uses `div_int` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock standing in for the oscillator output |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_int | input | NW | Integer part of the division ratio |
| div_frac | input | FW | Fraction numerator, below `div_mod` |
| div_mod | input | FW | Fraction denominator, nonzero |
| fb_pulse | output | 1 | One-clock pulse at the end of each feedback cycle |
| cyc_int | output | NW | Integer length of the cycle in progress |

## Verification
On every cycle the assertions check four things:
- the pulse is one clock wide;
- the pulse-to-pulse distance equals the reported integer;
- the reported integer changes only at a boundary, and there takes one of the two values allowed by the integer setting;
- the first cycle after reset uses the plain integer.

Other behaviours need whole sequences of cycles, so only the bench's scenarios can show them:
- the exact carry pattern of the accumulator;
- the average ratio over a full modulus period;
- the deferral of mid-cycle setting changes;
- the clearing of the accumulator by a reset in the middle of a run.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    // Feedback-cycle controller states
    typedef enum logic [1:0] {
        FB_LOAD = 2'd0,   // first set-up clock after reset
        FB_FIVE = 2'd1,   // prescaler periods dividing by 5
        FB_FOUR = 2'd2    // prescaler periods dividing by 4
    } fb_state_e;

    localparam int unsigned PRE_LO = 4;   // low prescaler modulus
    localparam int unsigned PRE_HI = 5;   // high prescaler modulus

endpackage

// File: rtl/fracn_sd_accum.sv
// First-order sigma-delta accumulator: chooses N or N+1 for the next cycle.
module fracn_sd_accum #(
    parameter int unsigned NW = 8,
    parameter int unsigned FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [NW-1:0] div_int,
    input  logic [FW-1:0] div_frac,
    input  logic [FW-1:0] div_mod,
    output logic [NW-1:0] ninst_next
);
    localparam int unsigned SW = FW + 1;

    logic [FW-1:0] acc_q;
    logic [SW-1:0] sum;
    logic          carry;
    logic [SW-1:0] rem;

    always_comb begin
        sum        = {1'b0, acc_q} + {1'b0, div_frac};
        carry      = (sum >= {1'b0, div_mod});
        rem        = sum - {1'b0, div_mod};
        ninst_next = div_int + {{(NW-1){1'b0}}, carry};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= carry ? rem[FW-1:0] : sum[FW-1:0];
        end
    end
endmodule

// File: rtl/fracn_ratio_split.sv
// Splits an instantaneous integer into N1 prescaler periods, N0 of them by 5.
module fracn_ratio_split #(
    parameter int unsigned NW = 8
) (
    input  logic [NW-1:0] ninst,
    output logic [NW-3:0] n1,
    output logic [1:0]    n0
);
    always_comb begin
        n1 = ninst[NW-1:2];
        n0 = ninst[1:0];
    end
endmodule

// File: rtl/fracn_prescaler.sv
// Dual-modulus 4/5 prescaler: reloads on command, ticks on its last count.
module fracn_prescaler (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic reload_five,
    output logic tick
);
    import fracn_pkg::*;

    localparam logic [2:0] TOP_LO = 3'(PRE_LO - 1);
    localparam logic [2:0] TOP_HI = 3'(PRE_HI - 1);

    logic [2:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= reload_five ? TOP_HI : TOP_LO;
        end else if (cnt_q != 3'd0) begin
            cnt_q <= cnt_q - 3'd1;
        end
    end

    assign tick = (cnt_q == 3'd0);
endmodule

// File: rtl/fracn_fb_divider.sv
// Fractional-N feedback divider: sigma-delta choice of N/N+1 per cycle,
// each cycle realised as 4*N1 + N0 with a 4/5 prescaler.
module fracn_fb_divider #(
    parameter int unsigned NW = 8,
    parameter int unsigned FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] div_int,
    input  logic [FW-1:0] div_frac,
    input  logic [FW-1:0] div_mod,
    output logic          fb_pulse,
    output logic [NW-1:0] cyc_int
);
    import fracn_pkg::*;

    localparam int unsigned N1W = NW - 2;
    localparam logic [N1W-1:0] ONE_P = N1W'(1);

    fb_state_e      state_q, state_d;
    logic [N1W-1:0] per_left_q, per_left_d;
    logic [1:0]     five_left_q, five_left_d;
    logic [NW-1:0]  cyc_q;

    logic           pre_tick;
    logic           reload, reload_five;
    logic           loading;
    logic           last_period;
    logic           wrap;
    logic [NW-1:0]  ninst_next;
    logic [N1W-1:0] n1_new;
    logic [1:0]     n0_new;

    fracn_sd_accum #(.NW(NW), .FW(FW)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (wrap),
        .div_int    (div_int),
        .div_frac   (div_frac),
        .div_mod    (div_mod),
        .ninst_next (ninst_next)
    );

    fracn_ratio_split #(.NW(NW)) u_split (
        .ninst (ninst_next),
        .n1    (n1_new),
        .n0    (n0_new)
    );

    fracn_prescaler u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .reload      (reload),
        .reload_five (reload_five),
        .tick        (pre_tick)
    );

    assign loading     = (state_q == FB_LOAD);
    assign last_period = !loading && pre_tick && (per_left_q == ONE_P);
    assign wrap        = loading || last_period;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= FB_LOAD;
            per_left_q  <= '0;
            five_left_q <= '0;
            cyc_q       <= '0;
        end else begin
            state_q     <= state_d;
            per_left_q  <= per_left_d;
            five_left_q <= five_left_d;
            if (wrap) begin
                cyc_q <= ninst_next;
            end
        end
    end

    // Next-state and prescaler control
    always_comb begin
        state_d     = state_q;
        per_left_d  = per_left_q;
        five_left_d = five_left_q;
        reload      = 1'b0;
        reload_five = 1'b0;
        unique case (state_q)
            FB_LOAD: begin                       // start
                per_left_d  = n1_new;
                five_left_d = n0_new;
                reload      = 1'b1;
                reload_five = (n0_new != 2'd0);
                state_d     = (n0_new != 2'd0) ? FB_FIVE : FB_FOUR;
            end
            FB_FIVE: begin
                if (pre_tick) begin
                    reload = 1'b1;
                    if (per_left_q == ONE_P) begin   // wrap
                        per_left_d  = n1_new;
                        five_left_d = n0_new;
                        reload_five = (n0_new != 2'd0);
                        state_d     = (n0_new != 2'd0) ? FB_FIVE : FB_FOUR;
                    end else if (five_left_q == 2'd1) begin  // swap
                        per_left_d  = per_left_q - ONE_P;
                        five_left_d = 2'd0;
                        reload_five = 1'b0;
                        state_d     = FB_FOUR;
                    end else begin                   // step
                        per_left_d  = per_left_q - ONE_P;
                        five_left_d = five_left_q - 2'd1;
                        reload_five = 1'b1;
                    end
                end
            end
            FB_FOUR: begin
                if (pre_tick) begin
                    reload = 1'b1;
                    if (per_left_q == ONE_P) begin   // wrap
                        per_left_d  = n1_new;
                        five_left_d = n0_new;
                        reload_five = (n0_new != 2'd0);
                        state_d     = (n0_new != 2'd0) ? FB_FIVE : FB_FOUR;
                    end else begin                   // step
                        per_left_d  = per_left_q - ONE_P;
                        reload_five = 1'b0;
                    end
                end
            end
            default: begin
                state_d = FB_LOAD;
            end
        endcase
    end

    // Outputs
    always_comb begin
        fb_pulse = last_period;
        cyc_int  = cyc_q;
    end
endmodule

// File: rtl/fracn_fb_divider_chk.sv
// Property checker bound to the feedback divider.
module fracn_fb_divider_chk #(
    parameter int unsigned NW = 8,
    parameter int unsigned FW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NW-1:0] div_int,
    input logic [FW-1:0] div_frac,
    input logic [FW-1:0] div_mod,
    input logic          fb_pulse,
    input logic [NW-1:0] cyc_int,
    input logic          loading
);
    logic [15:0] len_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_cnt <= '0;
        end else if (loading || fb_pulse) begin
            len_cnt <= 16'd1;
        end else begin
            len_cnt <= len_cnt + 16'd1;
        end
    end

    p_one_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    p_len_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |-> (len_cnt == {{(16-NW){1'b0}}, cyc_int}));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fb_pulse && !loading) |=> $stable(cyc_int));

    p_int_choice_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> (cyc_int == $past(div_int) ||
                      cyc_int == NW'($past(div_int) + 1'b1)));

    p_first_n_r1: assert property (@(posedge clk) disable iff (!rst_n)
        loading |=> (cyc_int == $past(div_int)));
endmodule

bind fracn_fb_divider fracn_fb_divider_chk #(.NW(NW), .FW(FW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_int  (div_int),
    .div_frac (div_frac),
    .div_mod  (div_mod),
    .fb_pulse (fb_pulse),
    .cyc_int  (cyc_int),
    .loading  (loading)
);

// File: tb/fracn_fb_divider_bench.sv
`timescale 1ns/1ps
module fracn_fb_divider_bench;
    localparam int NW = 8;
    localparam int FW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] div_int = 8'd12;
    logic [FW-1:0] div_frac = '0;
    logic [FW-1:0] div_mod = 8'd1;
    logic          fb_pulse;
    logic [NW-1:0] cyc_int;

    int n_checks = 0;
    int n_fail   = 0;
    int m_acc    = 0;
    int m_next   = 0;
    int last_len = 0;

    always #2.5 clk = ~clk;

    fracn_fb_divider #(.NW(NW), .FW(FW)) u_fracn_fb_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_int  (div_int),
        .div_frac (div_frac),
        .div_mod  (div_mod),
        .fb_pulse (fb_pulse),
        .cyc_int  (cyc_int)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference accumulator: the choice made at a boundary with the current settings
    task automatic model_step();
        int sum;
        sum = m_acc + int'(div_frac);
        if (sum >= int'(div_mod)) begin
            m_acc  = sum - int'(div_mod);
            m_next = int'(div_int) + 1;
        end else begin
            m_acc  = sum;
            m_next = int'(div_int);
        end
    endtask

    task automatic do_reset(input int n, input int f, input int m);
        @(negedge clk);
        rst_n    = 1'b0;
        div_int  = NW'(n);
        div_frac = FW'(f);
        div_mod  = FW'(m);
        repeat (3) @(negedge clk);
        check(fb_pulse == 1'b0, "R1 pulse in reset", int'(fb_pulse), 0);
        check(cyc_int == '0, "R1 cyc_int in reset", int'(cyc_int), 0);
        rst_n = 1'b1;
        m_acc = 0;
        model_step();
    endtask

    // Measure one feedback cycle; optionally change settings at clock chg_at.
    task automatic run_cycle(input string req, input int chg_at,
                             input int nn, input int nf, input int nm);
        int len;
        int cyc_first;
        len = 0;
        cyc_first = -1;
        do begin
            @(negedge clk);
            len++;
            if (len == 1) begin
                cyc_first = int'(cyc_int);
                check(!fb_pulse, "R3 pulse width", int'(fb_pulse), 0);
            end
            if (len == chg_at) begin
                div_int  = NW'(nn);
                div_frac = FW'(nf);
                div_mod  = FW'(nm);
            end
        end while (!fb_pulse && len < 1000);
        check(len < 1000, "watchdog cycle", len, m_next);
        check(len == m_next, {req, " cycle length"}, len, m_next);
        check(int'(cyc_int) == m_next, "R8 cyc_int value", int'(cyc_int), m_next);
        check(int'(cyc_int) == cyc_first, "R8 cyc_int stable", int'(cyc_int), cyc_first);
        last_len = len;
        model_step();
    endtask

    task automatic t_reset_first();   // R1, R2
        do_reset(12, 0, 1);
        run_cycle("R1", 0, 0, 0, 1);
        check(last_len == 12, "R1 first cycle", last_len, 12);
        run_cycle("R2", 0, 0, 0, 1);
    endtask

    task automatic t_integer();       // R5
        do_reset(37, 0, 5);
        for (int i = 0; i < 4; i++) begin
            run_cycle("R5", 0, 0, 0, 1);
            check(last_len == 37, "R5 integer length", last_len, 37);
        end
    endtask

    task automatic t_frac_pattern();  // R4
        int exp_pat[6] = '{12, 12, 13, 12, 12, 13};
        do_reset(12, 1, 3);
        for (int i = 0; i < 6; i++) begin
            run_cycle("R4", 0, 0, 0, 1);
            check(last_len == exp_pat[i], "R4 carry pattern", last_len, exp_pat[i]);
        end
    endtask

    task automatic t_average();       // R6
        int total;
        total = 0;
        do_reset(20, 5, 7);
        for (int i = 0; i < 7; i++) begin
            run_cycle("R6", 0, 0, 0, 1);
            total += last_len;
        end
        check(total == 145, "R6 average ratio", total, 145);
    endtask

    task automatic t_residues();      // R9
        for (int n = 12; n <= 15; n++) begin
            do_reset(n, 0, 1);
            run_cycle("R9", 0, 0, 0, 1);
            check(last_len == n, "R9 residue length", last_len, n);
        end
        do_reset(254, 1, 2);
        run_cycle("R9", 0, 0, 0, 1);
        check(last_len == 254, "R9 top minus one", last_len, 254);
        run_cycle("R9", 0, 0, 0, 1);
        check(last_len == 255, "R9 top value", last_len, 255);
    endtask

    task automatic t_midcycle();      // R7
        do_reset(20, 0, 1);
        run_cycle("R7", 0, 0, 0, 1);
        run_cycle("R7", 8, 30, 1, 2);
        check(last_len == 20, "R7 current cycle kept", last_len, 20);
        run_cycle("R7", 0, 0, 0, 1);
        check(last_len == 30, "R7 new value applied", last_len, 30);
        run_cycle("R7", 0, 0, 0, 1);
        check(last_len == 31, "R7 new fraction applied", last_len, 31);
    endtask

    task automatic t_reset_mid();     // R10
        do_reset(12, 2, 3);
        run_cycle("R10", 0, 0, 0, 1);
        run_cycle("R10", 0, 0, 0, 1);
        check(last_len == 13, "R10 carry before reset", last_len, 13);
        do_reset(12, 2, 3);
        run_cycle("R10", 0, 0, 0, 1);
        check(last_len == 12, "R10 accumulator cleared", last_len, 12);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_first();
        t_integer();
        t_frac_pattern();
        t_average();
        t_residues();
        t_midcycle();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule